// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM with Late Write

This block models a flow-through synchronous static memory with a word of four 9-bit byte lanes and a depth set by an address-width parameter. Every control input is captured on the rising clock edge. A cycle is opened by a load (load/advance LOW), which fixes the cycle type and the chip selection. Cycles with load/advance HIGH continue that cycle and step a 2-bit burst offset. Read data reaches the output in the cycle after its address edge, with no output register in the path.

Write data is taken one enabled edge after the address and byte enables, so the bus can alternate between reads and writes with no idle cycles. A clock-enable input freezes the whole pipeline, including a write still waiting for its data. A standby input also freezes the pipeline and keeps the contents. An asynchronous output enable gates the read-data valid flag, and that flag stands in for a tristate data bus.

Top module: `zbt_sram`

## Requirements
- R1: Read data is flow-through: after a read load on an enabled edge, `rdata` shows the word at that address and `rdata_vld` is 1 during the following cycle, with no extra register.
- R2: On an enabled edge with `adv_ld_n` LOW and the device selected, a new address is loaded and `rd_wr_n` sets the cycle type: HIGH is a read, LOW is a write.
- R3: On an enabled edge with `adv_ld_n` HIGH, `rd_wr_n`, the chip enables and `addr` are ignored. The cycle type is kept and the burst advances by one beat.
- R4: Burst order: with base offset b = `addr[1:0]` at load, beat k uses offset (b+k) mod 4 when `burst_ilv` is 0 and b XOR k when it is 1. It wraps after four beats, and the upper address bits stay fixed.
- R5: Late write: write data is sampled from `wdata` on the enabled edge after the write's address edge. Reads and writes can alternate on consecutive edges, and a read loaded on the same edge that completes a write to that address returns the new data.
- R6: Byte enables are active LOW and sampled with each write address. `bw_n[i]` gates lane i, which is `wdata[9i+8:9i]`. Lanes whose enable is HIGH keep their old contents.
- R7: A load is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. Any other load is a deselect cycle: nothing is written, `rdata_vld` is 0, and advances after it stay deselected. A write already waiting for its data still completes on that edge.
- R8: While `cke_n` is HIGH, clock edges are ignored and all state is held, including a write waiting for its data. That write takes `wdata` on the next enabled edge.
- R9: While `zz` is HIGH, every other input is ignored, the memory contents and cycle state are kept, and `rdata_vld` is 0.
- R10: `rdata_vld` is 1 only during a read cycle while the asynchronous `oe_n` is LOW.
- R11: Reset: with `rst_n` LOW at a rising edge, the block enters the idle state and `rdata_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_n | input | 1 | Clock enable, active LOW |
| zz | input | 1 | Standby, active HIGH |
| adv_ld_n | input | 1 | LOW loads a new address, HIGH advances the burst |
| rd_wr_n | input | 1 | Cycle type on load: HIGH read, LOW write |
| ce1_n | input | 1 | Chip enable, active LOW |
| ce2 | input | 1 | Chip enable, active HIGH |
| ce3_n | input | 1 | Chip enable, active LOW |
| bw_n | input | 4 | Byte lane write enables, active LOW |
| addr | input | ADDR_W | Word address |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| wdata | input | 36 | Write data, one cycle after its address |
| oe_n | input | 1 | Asynchronous output enable, active LOW |
| rdata | output | 36 | Flow-through read data |
| rdata_vld | output | 1 | Read data driven (stands in for the bus drivers) |

## Verification
Two things can happen on the same edge: a write still waiting for its data finishes, and a new load begins. The new load may be a read of the same word, a deselect, or a load that a clock-enable stall has delayed. The bench sets up each case by issuing the write load and then, on the very next enabled edge, the read, the deselect or the stalled read. It judges the result from the word shown on `rdata` in the following cycle. That word must be the freshly merged lanes, or, after a deselect, the word read back later.

// File: rtl/zbt_pkg.sv
// Shared types for the zero-turnaround SRAM model.
package zbt_pkg;

    // Kind of the cycle currently open in the pipeline.
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } zbt_op_e;

    // Offset of a burst beat within the aligned four-word group.
    function automatic logic [1:0] burst_offset(
        input logic [1:0] base,
        input logic [1:0] beat,
        input logic       interleaved
    );
        return interleaved ? (base ^ beat) : (base + beat);
    endfunction

endpackage

// File: rtl/zbt_burst_ctr.sv
// Burst address generator.
// Holds the loaded base address and a 2-bit beat count. The beat count
// resets on a load and steps on an advance. Assumes ADDR_W >= 2 and that
// the burst order input is static while a burst runs.
module zbt_burst_ctr #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              load,
    input  logic              interleaved,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic [ADDR_W-1:0] cur_addr
);
    import zbt_pkg::*;

    localparam int HI_W = ADDR_W - 2;

    logic [ADDR_W-1:0] base_q;
    logic [1:0]        beat_q;

    // Load the base on a load edge, otherwise step the beat on enabled edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
        end else if (step_en) begin
            if (load) begin
                base_q <= ld_addr;
                beat_q <= '0;
            end else begin
                beat_q <= beat_q + 2'd1;
            end
        end
    end

    // Upper bits come from the base, the low two bits from the burst order.
    always_comb begin
        cur_addr = {base_q[ADDR_W-1:2], burst_offset(base_q[1:0], beat_q, interleaved)};
    end

    AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load) |=> (beat_q == $past(beat_q) + 2'd1)); // R4

    AST_BURST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load) |=> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2]))); // R4

    AST_BURST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> ($stable(base_q) && $stable(beat_q))); // R8

    logic [HI_W-1:0] unused_hi;
    assign unused_hi = '0;

endmodule

// File: rtl/zbt_ctrl.sv
// Cycle control for the SRAM model.
// Decides the cycle type and chip selection on load edges and keeps them on
// advance edges. It registers the byte enables on every enabled edge and
// issues lane write strobes one enabled edge after a write address. Assumes
// the chip enables and read/write matter only on load edges.
module zbt_ctrl #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke_n,
    input  logic             zz,
    input  logic             adv_ld_n,
    input  logic             rd_wr_n,
    input  logic             ce1_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic [LANES-1:0] bw_n,
    output logic             step_en,
    output logic             load,
    output zbt_pkg::zbt_op_e op_q,
    output logic [LANES-1:0] lane_we
);
    import zbt_pkg::*;

    logic             selected;
    logic [LANES-1:0] bw_n_q;
    zbt_op_e          op_d;

    // An edge counts only when the clock is enabled and standby is off.
    always_comb begin
        step_en  = !cke_n && !zz;
        load     = !adv_ld_n;
        selected = !ce1_n && ce2 && !ce3_n;
    end

    // Next cycle type: decided on a load, inherited on an advance.
    always_comb begin
        if (load) begin
            if (!selected)    op_d = OP_IDLE;
            else if (rd_wr_n) op_d = OP_RD;
            else              op_d = OP_WR;
        end else begin
            op_d = op_q;
        end
    end

    // Cycle type and byte-enable pipeline registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_IDLE;
            bw_n_q <= '1;
        end else if (step_en) begin
            op_q   <= op_d;
            bw_n_q <= bw_n;
        end
    end

    // Late write: lanes are written on the enabled edge after the address.
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane_we
            assign lane_we[g] = step_en && (op_q == OP_WR) && !bw_n_q[g];
        end
    endgenerate

    AST_LOAD_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !zz && !adv_ld_n && !ce1_n && ce2 && !ce3_n)
        |=> (op_q == ($past(rd_wr_n) ? OP_RD : OP_WR))); // R2

    AST_TYPE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !zz && adv_ld_n) |=> $stable(op_q)); // R3

    AST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !zz && !adv_ld_n && (ce1_n || !ce2 || ce3_n)) |=> (op_q == OP_IDLE)); // R7

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(op_q) && $stable(bw_n_q))); // R8

    AST_STANDBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        zz |=> ($stable(op_q) && $stable(bw_n_q))); // R9

endmodule

// File: rtl/zbt_mem_array.sv
// Storage array split into independently writable byte lanes.
// Single address shared by the read and the write. The read is combinational
// (flow-through); a write lands on the clock edge. Contents are not reset.
module zbt_mem_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        lane_we,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic [LANE_W-1:0] store_q [DEPTH];

            // Write this lane when its strobe is set.
            always_ff @(posedge clk) begin
                if (lane_we[g]) begin
                    store_q[addr] <= wdata[g*LANE_W +: LANE_W];
                end
            end

            assign rdata[g*LANE_W +: LANE_W] = store_q[addr];
        end
    endgenerate

endmodule

// File: rtl/zbt_sram.sv
// Zero-turnaround flow-through synchronous SRAM, top level.
// Ties together the cycle control, the burst generator and the lane array.
// The read path has no output register. The valid flag replaces a tristate
// bus. Assumes burst_ilv changes only while no burst is running.
module zbt_sram #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cke_n,
    input  logic                    zz,
    input  logic                    adv_ld_n,
    input  logic                    rd_wr_n,
    input  logic                    ce1_n,
    input  logic                    ce2,
    input  logic                    ce3_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    burst_ilv,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    oe_n,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_vld
);
    import zbt_pkg::*;

    logic              step_en;
    logic              load;
    zbt_op_e           op_q;
    logic [LANES-1:0]  lane_we;
    logic [ADDR_W-1:0] cur_addr;

    zbt_ctrl #(.LANES(LANES)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cke_n    (cke_n),
        .zz       (zz),
        .adv_ld_n (adv_ld_n),
        .rd_wr_n  (rd_wr_n),
        .ce1_n    (ce1_n),
        .ce2      (ce2),
        .ce3_n    (ce3_n),
        .bw_n     (bw_n),
        .step_en  (step_en),
        .load     (load),
        .op_q     (op_q),
        .lane_we  (lane_we)
    );

    zbt_burst_ctr #(.ADDR_W(ADDR_W)) u_burst (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_en     (step_en),
        .load        (load),
        .interleaved (burst_ilv),
        .ld_addr     (addr),
        .cur_addr    (cur_addr)
    );

    zbt_mem_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .addr    (cur_addr),
        .lane_we (lane_we),
        .wdata   (wdata),
        .rdata   (rdata)
    );

    // Output drivers on only for a read, with outputs enabled and no standby.
    always_comb begin
        rdata_vld = (op_q == OP_RD) && !oe_n && !zz;
    end

    AST_STANDBY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        zz |-> (lane_we == '0)); // R9

    AST_STALL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |-> (lane_we == '0)); // R8

endmodule

// File: tb/zbt_sram_bench.sv
module zbt_sram_bench;

    localparam int AW = 6;
    localparam int DW = 36;

    typedef struct packed {
        logic          adv;
        logic          rw;
        logic          sel;
        logic [3:0]    bw;
        logic [AW-1:0] a;
        logic [DW-1:0] wd;
        logic          ev;
        logic [DW-1:0] ed;
    } vec_t;

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                            input logic [DW-1:0] new_w,
                                            input logic [3:0] bwn);
        logic [DW-1:0] r;
        r = old_w;
        for (int i = 0; i < 4; i++) if (!bwn[i]) r[i*9 +: 9] = new_w[i*9 +: 9];
        return r;
    endfunction

    localparam logic [DW-1:0] D0 = 36'h1_2345_6789;
    localparam logic [DW-1:0] D1 = 36'hA_BCDE_F012;
    localparam logic [DW-1:0] D2 = 36'h5_5AA5_33CC;
    localparam logic [DW-1:0] D3 = 36'h7_0F0F_1E2D;
    localparam logic [DW-1:0] E0 = 36'h8_1111_1110;
    localparam logic [DW-1:0] E1 = 36'h9_2222_2221;
    localparam logic [DW-1:0] E2 = 36'hC_3333_3332;
    localparam logic [DW-1:0] E3 = 36'hD_4444_4443;
    localparam logic [DW-1:0] JK = 36'hF_FFFF_FFFF;
    localparam logic [DW-1:0] F1 = 36'h2_468A_CE13;
    localparam logic [DW-1:0] M5 = merge(D1, D2, 4'b1010);

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b1, 4'h0, 6'd4, '0, 1'b0, '0},  // write 4
        '{1'b0, 1'b0, 1'b1, 4'h0, 6'd5, D0, 1'b0, '0},  // R5 data for 4, write 5
        '{1'b0, 1'b1, 1'b1, 4'hF, 6'd4, D1, 1'b1, D0},  // R1 R5 read right after write
        '{1'b0, 1'b1, 1'b1, 4'hF, 6'd5, '0, 1'b1, D1},
        '{1'b0, 1'b0, 1'b1, 4'hA, 6'd5, '0, 1'b0, '0},  // R6 partial write
        '{1'b0, 1'b1, 1'b1, 4'hF, 6'd5, D2, 1'b1, M5},  // R5 R6 same-address read
        '{1'b0, 1'b0, 1'b1, 4'h0, 6'd8, '0, 1'b0, '0},  // burst write base 8
        '{1'b1, 1'b1, 1'b1, 4'h0, 6'd0, E0, 1'b0, '0},  // R3 rw ignored
        '{1'b1, 1'b1, 1'b1, 4'h0, 6'd0, E1, 1'b0, '0},
        '{1'b1, 1'b0, 1'b1, 4'h0, 6'd0, E2, 1'b0, '0},
        '{1'b0, 1'b1, 1'b1, 4'hF, 6'd9, E3, 1'b1, E1},  // R4 linear base 1
        '{1'b1, 1'b0, 1'b1, 4'h0, 6'd0, '0, 1'b1, E2},
        '{1'b1, 1'b0, 1'b1, 4'hF, 6'd0, '0, 1'b1, E3},
        '{1'b1, 1'b1, 1'b1, 4'hF, 6'd0, '0, 1'b1, E0},  // R4 wrap
        '{1'b0, 1'b1, 1'b0, 4'hF, 6'd0, '0, 1'b0, '0},  // R7 deselect
        '{1'b1, 1'b1, 1'b1, 4'hF, 6'd0, '0, 1'b0, '0},  // R7 advance stays off
        '{1'b0, 1'b0, 1'b0, 4'h0, 6'd4, '0, 1'b0, '0},  // R7 deselected write
        '{1'b0, 1'b1, 1'b1, 4'hF, 6'd4, JK, 1'b1, D0},  // R7 nothing written
        '{1'b0, 1'b0, 1'b1, 4'h0, 6'd6, '0, 1'b0, '0},
        '{1'b0, 1'b1, 1'b0, 4'hF, 6'd0, D3, 1'b0, '0},  // R7 write completes on deselect
        '{1'b0, 1'b1, 1'b1, 4'hF, 6'd6, '0, 1'b1, D3}
    };

    logic clk = 1'b0;
    logic rst_n, cke_n, zz, adv_ld_n, rd_wr_n, ce1_n, ce2, ce3_n, burst_ilv, oe_n;
    logic [3:0] bw_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata, rdata;
    logic rdata_vld;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    zbt_sram u_zbt_sram (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .zz(zz), .adv_ld_n(adv_ld_n),
        .rd_wr_n(rd_wr_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .bw_n(bw_n),
        .addr(addr), .burst_ilv(burst_ilv), .wdata(wdata), .oe_n(oe_n),
        .rdata(rdata), .rdata_vld(rdata_vld)
    );

    task automatic chk(input string req, input logic ev, input logic [DW-1:0] ed);
        checks++;
        if (rdata_vld !== ev || (ev && rdata !== ed)) begin
            errors++;
            $display("FAIL %s: vld=%0b data=%h expected vld=%0b data=%h",
                     req, rdata_vld, rdata, ev, ed);
        end
    endtask

    task automatic drv(input logic adv, input logic rw, input logic c1n, input logic c2,
                       input logic c3n, input logic [3:0] bw, input logic [AW-1:0] a,
                       input logic [DW-1:0] wd);
        adv_ld_n = adv; rd_wr_n = rw; ce1_n = c1n; ce2 = c2; ce3_n = c3n;
        bw_n = bw; addr = a; wdata = wd;
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cke_n = 1'b0; zz = 1'b0; burst_ilv = 1'b0; oe_n = 1'b0;
        drv(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'hF, '0, '0);
        tick(); tick();
        chk("R11 reset idle", 1'b0, '0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drv(VECS[i].adv, VECS[i].rw, 1'b0, VECS[i].sel, 1'b0,
                VECS[i].bw, VECS[i].a, VECS[i].wd);
            tick();
            chk($sformatf("R1/R2/R5 vector %0d", i), VECS[i].ev, VECS[i].ed);
        end

        // R4 interleaved order from base offset 1: 9, 8, 11, 10
        burst_ilv = 1'b1;
        drv(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'hF, 6'd9, '0); tick(); chk("R4 ilv beat0", 1'b1, E1);
        drv(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'hF, 6'd0, '0); tick(); chk("R4 ilv beat1", 1'b1, E0);
        tick(); chk("R4 ilv beat2", 1'b1, E3);
        tick(); chk("R4 ilv beat3", 1'b1, E2);
        burst_ilv = 1'b0;

        // R8 stall with a write waiting for its data
        drv(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 6'd20, '0); tick();
        cke_n = 1'b1;
        drv(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'hF, 6'd4, JK); tick(); tick();
        chk("R8 stall holds write cycle", 1'b0, '0);
        cke_n = 1'b0;
        drv(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'hF, 6'd20, F1); tick();
        chk("R8 late data after stall", 1'b1, F1);
        cke_n = 1'b1;
        drv(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 6'd4, JK); tick();
        chk("R8 stall holds read", 1'b1, F1);
        cke_n = 1'b0;

        // R9 standby
        zz = 1'b1; #1;
        chk("R9 standby no drive", 1'b0, '0);
        tick(); tick();
        zz = 1'b0; #1;
        chk("R9 state and contents kept", 1'b1, F1);

        // R10 output enable
        oe_n = 1'b1; #1;
        chk("R10 oe high", 1'b0, '0);
        oe_n = 1'b0; #1;
        chk("R10 oe low", 1'b1, F1);

        // R7 deselect through the first enable
        drv(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'hF, 6'd20, '0); tick();
        chk("R7 ce1_n deselect", 1'b0, '0);

        // R11 reset in the middle of a read
        drv(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'hF, 6'd20, '0); tick();
        chk("R2 read load", 1'b1, F1);
        rst_n = 1'b0; tick();
        chk("R11 reset during read", 1'b0, '0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule